// File: doc/BRIEF.md
# Serial EEPROM target, 512 x 8, SPI mode 0

This block behaves like a small byte-organized serial EEPROM on an SPI bus in mode 0. It runs on a system clock and oversamples the four bus pins (clock, active-low select, data in, active-low write guard) through a synchronizer. Serial data is taken on the rising edge of the bus clock and driven on the falling edge. The bus clock must stay low for at least 3 system clocks and high for at least 3 system clocks. A host selects the device, shifts in one instruction byte, and then sends the operands or reads data. For the two array operations, bit 3 of the instruction byte carries address bit 8. The byte that follows gives the low eight address bits, so a single address byte reaches all 512 locations.

The model has five instructions: array read, page write, write-enable, status read and status write. An accepted write is collected in a 16-byte page buffer and committed when the select line rises. The status register then reports busy for a programmable number of system clocks. Two block-protect bits guard the top quarter, the top half or the whole array. The hold function does not exist, because its pin is taken as always inactive. The bus is a plain serial pin set, with no valid/ready back-pressure: the host owns the clock, and the model keeps up with any clock that meets the minimum phase width above.

Top module: `eeprom_spi_target`

## Requirements
- R1: After reset, every array location reads 0xFF and the status byte reads 0x00.
- R2: The instruction byte arrives MSB first. With bits 7..4 zero, low bits 011 select READ and 010 select WRITE, and bit 3 is address bit 8. Write-enable is exactly 0x06, status read is exactly 0x05 and status write is exactly 0x01. Any other value, such as 0x0E, makes the frame have no effect.
- R3: Bits are sampled on the rising edge of the bus clock and the output changes on the falling edge, MSB first. The output is 0 whenever the select line is high.
- R4: A status read returns {0000, BP1, BP0, WEL, BUSY}, with BUSY in bit 0 and WEL in bit 1. The byte repeats for as long as the host keeps clocking.
- R5: A write-enable frame of exactly 8 bits sets WEL when the select line rises.
- R6: A WRITE frame that arrives while WEL is clear leaves the array and the status unchanged.
- R7: The data bytes of a write go to successive addresses, and the address wraps within the current 16-byte page. The write commits when the select line rises after one or more whole data bytes. A partial final byte, or no data at all, aborts the write and clears WEL.
- R8: An accepted write or status write holds BUSY at 1 for WRITE_CYCLES system clocks. WRITE_CYCLES is taken as at least PAGE_BYTES. When the cycle ends, BUSY and WEL both clear.
- R9: While BUSY is 1, only the status read is decoded. Any other frame has no effect, and a READ attempted then returns zeros.
- R10: The block-protect setting selects the guarded region. 00 guards nothing, 01 guards addresses 384..511, 10 guards 256..511 and 11 guards the whole array. Bytes aimed at guarded addresses are dropped.
- R11: A status write is accepted only when it is exactly 16 bits long, WEL is set and the guard pin is high. It then copies data bits 3..2 into BP1..BP0 and changes nothing else. A status write that is refused while WEL is set clears WEL and starts no busy cycle.
- R12: A READ streams bytes from successive addresses for as long as the host clocks, and wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Bus serial clock, mode 0 |
| csn_i | input | 1 | Active-low device select |
| sdi_i | input | 1 | Serial data from the host |
| wpn_i | input | 1 | Active-low guard that blocks status writes |
| sdo_o | output | 1 | Serial data to the host |

## Verification
The bench builds the block with 16-byte pages, a 300-clock write cycle and a two-stage synchronizer. With these values a full 32-page write sweep and one continuous 514-byte read stay within the cycle budget. That reach lets the bench compare every location with an arithmetic pattern, cross the 511-to-0 wrap and land frames inside the busy window. With the short write cycle it can also test each protect setting at its boundary addresses.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [7:0] INS_WREN  = 8'h06;
  localparam logic [7:0] INS_RDSR  = 8'h05;
  localparam logic [7:0] INS_WRSR  = 8'h01;
  localparam logic [2:0] OPC_READ  = 3'b011;
  localparam logic [2:0] OPC_WRITE = 3'b010;

  typedef enum logic [2:0] {
    F_IDLE, F_SKIP, F_READ, F_WRITE, F_WREN, F_RDSR, F_WRSR
  } frame_e;

  // Block-protect decode: top quarter, top half or everything
  function automatic logic is_guarded(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic sdi_i,
  input  logic wpn_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic csn_s,
  output logic cs_rise,
  output logic cs_fall,
  output logic sdi_s,
  output logic wpn_s
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] RST_VAL = 4'b1010; // wpn=1 sdi=0 csn=1 sck=0

  logic [NPIN-1:0] raw, s;
  logic sck_d, csn_d;

  assign raw = {wpn_i, sdi_i, csn_i, sck_i};

  // Equal-depth chains keep data and clock edges aligned
  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= s[0];
      csn_d <= s[1];
    end
  end

  assign sck_rise = s[0] & ~sck_d;
  assign sck_fall = ~s[0] & sck_d;
  assign csn_s    = s[1];
  assign cs_rise  = s[1] & ~csn_d;
  assign cs_fall  = ~s[1] & csn_d;
  assign sdi_s    = s[2];
  assign wpn_s    = s[3];
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          we,
  input  logic [$clog2(PAGE_BYTES)-1:0] widx,
  input  logic [DW-1:0]                 wdata,
  input  logic [$clog2(PAGE_BYTES)-1:0] ridx,
  output logic [DW-1:0]                 rdata,
  output logic                          rvalid
);
  logic [DW-1:0]         slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) slot[i] <= '0;
    end else if (clr) begin
      filled <= '0;
    end else if (we) begin
      slot[widx]   <= wdata;
      filled[widx] <= 1'b1;
    end
  end

  assign rdata  = slot[ridx];
  assign rvalid = filled[ridx];
endmodule

// File: rtl/eeprom_spi_target.sv
module eeprom_spi_target
  import ee_spi_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic sdi_i,
  input  logic wpn_i,
  output logic sdo_o
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int BUSY_CYC = (WRITE_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WRITE_CYCLES;
  localparam int CNT_W    = $clog2(BUSY_CYC + 1);

  logic sck_rise, sck_fall, csn_s, cs_rise, cs_fall, sdi_s, wpn_s;

  frame_e             frame_q, dec_frame;
  logic [2:0]         bitin_q, obit_q;
  logic [1:0]         bcnt_q, wrsr_bp_q, bp_q;
  logic [7:0]         shreg_q, rx_byte, status, tx_byte, mem_rdata, pb_rdata;
  logic [6:0]         oshift_q;
  logic               a8_q, wel_q, so_q, commit_q, pb_valid;
  logic [ADDR_W-1:0]  addr_q, mem_waddr;
  logic [OFF_W-1:0]   cidx_q;
  logic [CNT_W-1:0]   wcnt_q;
  logic               busy, bit_rx, byte_end, tx_phase, mem_we, pb_we, pb_clr;

  ee_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .csn_i(csn_i), .sdi_i(sdi_i), .wpn_i(wpn_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .csn_s(csn_s), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .sdi_s(sdi_s), .wpn_s(wpn_s)
  );

  assign busy     = (wcnt_q != '0);
  assign status   = {4'b0000, bp_q, wel_q, busy};
  assign bit_rx   = sck_rise & ~csn_s & ~cs_fall;
  assign rx_byte  = {shreg_q[6:0], sdi_s};
  assign byte_end = bit_rx & (bitin_q == 3'd7);
  assign tx_phase = ~csn_s & (((frame_q == F_READ) && (bcnt_q >= 2'd2)) ||
                              ((frame_q == F_RDSR) && (bcnt_q >= 2'd1)));
  assign tx_byte  = (frame_q == F_RDSR) ? status : mem_rdata;

  always_comb begin
    dec_frame = F_SKIP;
    if (busy && rx_byte != INS_RDSR)                          dec_frame = F_SKIP;
    else if (rx_byte[7:4] == 4'd0 && rx_byte[2:0] == OPC_READ)  dec_frame = F_READ;
    else if (rx_byte[7:4] == 4'd0 && rx_byte[2:0] == OPC_WRITE) dec_frame = F_WRITE;
    else if (rx_byte == INS_WREN)                             dec_frame = F_WREN;
    else if (rx_byte == INS_RDSR)                             dec_frame = F_RDSR;
    else if (rx_byte == INS_WRSR)                             dec_frame = F_WRSR;
  end

  assign pb_clr = byte_end & (bcnt_q == 2'd0) & (dec_frame == F_WRITE);
  assign pb_we  = byte_end & (frame_q == F_WRITE) & (bcnt_q >= 2'd2);

  ee_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DW(8)) pbuf_i (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we), .widx(addr_q[OFF_W-1:0]),
    .wdata(rx_byte), .ridx(cidx_q), .rdata(pb_rdata), .rvalid(pb_valid)
  );

  assign mem_waddr = {addr_q[ADDR_W-1:OFF_W], cidx_q};
  assign mem_we    = commit_q & pb_valid & ~is_guarded(bp_q, mem_waddr);

  ee_array #(.AW(ADDR_W), .DW(8)) array_i (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(pb_rdata),
    .raddr(addr_q), .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= F_IDLE;  bitin_q <= '0;  bcnt_q <= '0;  shreg_q <= '0;
      a8_q <= 1'b0;       addr_q <= '0;   wrsr_bp_q <= '0;
      wel_q <= 1'b0;      bp_q <= '0;     wcnt_q <= '0;
      commit_q <= 1'b0;   cidx_q <= '0;
      so_q <= 1'b0;       oshift_q <= '0; obit_q <= '0;
    end else begin
      // internal write cycle
      if (busy) begin
        wcnt_q <= wcnt_q - 1'b1;
        if (wcnt_q == CNT_W'(1)) wel_q <= 1'b0;
      end
      if (commit_q) begin
        cidx_q <= cidx_q + 1'b1;
        if (cidx_q == OFF_W'(PAGE_BYTES - 1)) commit_q <= 1'b0;
      end

      if (cs_fall) begin
        frame_q <= F_IDLE;
        bitin_q <= '0;
        bcnt_q  <= '0;
        obit_q  <= '0;
      end else if (bit_rx) begin
        shreg_q <= rx_byte;
        bitin_q <= bitin_q + 1'b1;
        if (bitin_q == 3'd7) begin
          if (bcnt_q != 2'd3) bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == 2'd0) begin
            frame_q <= dec_frame;
            a8_q    <= rx_byte[3];
          end else if (bcnt_q == 2'd1) begin
            if (frame_q == F_READ || frame_q == F_WRITE) addr_q <= {a8_q, rx_byte};
            if (frame_q == F_WRSR) wrsr_bp_q <= rx_byte[3:2];
          end else if (frame_q == F_WRITE) begin
            addr_q[OFF_W-1:0] <= addr_q[OFF_W-1:0] + 1'b1;
          end
        end
      end

      // output shifter, falling edge
      if (sck_fall && tx_phase) begin
        if (obit_q == 3'd0) begin
          so_q     <= tx_byte[7];
          oshift_q <= tx_byte[6:0];
          obit_q   <= 3'd7;
          if (frame_q == F_READ) addr_q <= addr_q + 1'b1;
        end else begin
          so_q     <= oshift_q[6];
          oshift_q <= {oshift_q[5:0], 1'b0};
          obit_q   <= obit_q - 1'b1;
        end
      end

      // end of frame actions
      if (cs_rise) begin
        so_q    <= 1'b0;
        frame_q <= F_IDLE;
        case (frame_q)
          F_WREN: if (bcnt_q == 2'd1 && bitin_q == 3'd0) wel_q <= 1'b1;
          F_WRITE: if (wel_q) begin
            if (bitin_q == 3'd0 && bcnt_q == 2'd3) begin
              wcnt_q   <= CNT_W'(BUSY_CYC);
              commit_q <= 1'b1;
              cidx_q   <= '0;
            end else begin
              wel_q <= 1'b0;
            end
          end
          F_WRSR: if (wel_q) begin
            if (bitin_q == 3'd0 && bcnt_q == 2'd2 && wpn_s) begin
              bp_q   <= wrsr_bp_q;
              wcnt_q <= CNT_W'(BUSY_CYC);
            end else begin
              wel_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_o = so_q;
endmodule

// File: rtl/ee_spi_checker.sv
module ee_spi_checker #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [1:0]        bp,
  input logic              busy,
  input logic              wel,
  input logic              csn_s,
  input logic              sdo
);
  localparam int WORDS    = 1 << ADDR_W;
  localparam int BUSY_CYC = (WRITE_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WRITE_CYCLES;

  logic        guarded;
  logic [31:0] run_q;

  assign guarded = (bp == 2'd3) ||
                   (bp == 2'd2 && int'(mem_waddr) >= WORDS / 2) ||
                   (bp == 2'd1 && int'(mem_waddr) >= (WORDS * 3) / 4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= '0;
  end

  p_we_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_busy_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 32'(BUSY_CYC)));

  p_wel_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  p_no_guarded_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !guarded);

  p_bp_moves_with_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> busy);

  p_sdo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !sdo);
endmodule

bind eeprom_spi_target ee_spi_checker #(
  .ADDR_W(ee_spi_pkg::ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_waddr(mem_waddr), .bp(bp_q),
  .busy(busy), .wel(wel_q), .csn_s(csn_s), .sdo(sdo_o)
);

// File: tb/eeprom_spi_target_tb_top.sv
`timescale 1ns/1ps
module eeprom_spi_target_tb_top;
  localparam int HALF  = 5;
  localparam int WCYC  = 300;
  localparam int PAGE  = 16;
  localparam int WORDS = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0, wpn = 1'b1;
  logic sdo;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [WORDS];
  logic [1:0] mbp = 2'd0;
  logic [7:0] s, r;

  always #2.5 clk = ~clk;

  eeprom_spi_target #(.PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi), .wpn_i(wpn), .sdo_o(sdo)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = tx[i];
      tick(HALF);
      rx[i] = sdo;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic sel();
    csn = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    csn = 1'b1;
    tick(8);
  endtask

  function automatic logic [7:0] ins(input logic [2:0] op, input int a);
    return {4'b0000, 1'(a >> 8), op};
  endfunction

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 5 + seed * 29 + 60) & 255);
  endfunction

  function automatic bit guarded(input logic [1:0] bp, input int a);
    return (bp == 2'd3) || (bp == 2'd2 && a >= 256) || (bp == 2'd1 && a >= 384);
  endfunction

  task automatic wren();
    logic [7:0] x;
    sel(); xbyte(8'h06, x); desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] x;
    sel(); xbyte(8'h05, x); xbyte(8'h00, st); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] x;
    sel(); xbyte(8'h01, x); xbyte(v, x); desel();
  endtask

  task automatic wr_frame(input int a, input int n, input int seed);
    logic [7:0] x;
    sel();
    xbyte(ins(3'b010, a), x);
    xbyte(8'(a), x);
    for (int i = 0; i < n; i++) xbyte(pat(a + i, seed), x);
    desel();
  endtask

  // expected effect of an accepted write: page-wrapped addresses, guarded bytes dropped
  task automatic model_write(input int a, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      int t;
      t = (a & ~(PAGE - 1)) | ((a + i) & (PAGE - 1));
      if (!guarded(mbp, t)) exp_mem[t] = pat(a + i, seed);
    end
  endtask

  task automatic rd_check(input int a, input int n, input string req);
    logic [7:0] x;
    sel();
    xbyte(ins(3'b011, a), x);
    xbyte(8'(a), x);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, x);
      chk(req, x, exp_mem[(a + i) % WORDS], "read data");
    end
    desel();
  endtask

  task automatic idle();
    tick(WCYC + 40);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) exp_mem[i] = 8'hFF;
    tick(10);
    rst_n = 1'b1;
    tick(10);

    // R1 reset state
    rdsr(s); chk("R1", s, 8'h00, "status after reset");
    rd_check(496, 16, "R1");

    // R2 write-enable code with bit 3 set is not decoded
    sel(); xbyte(8'h0E, r); desel();
    rdsr(s); chk("R2", s, 8'h00, "status after 0x0E");

    // R5 write enable
    wren();
    rdsr(s); chk("R5", s, 8'h02, "status after WREN");

    // R8 R4 sweep: every page written with a full 16-byte frame
    for (int p = 0; p < WORDS / PAGE; p++) begin
      wren();
      wr_frame(p * PAGE, PAGE, 1);
      model_write(p * PAGE, PAGE, 1);
      rdsr(s); chk("R8", s, 8'h03, "status during write cycle");
      idle();
      rdsr(s); chk("R8", s, 8'h00, "status after write cycle");
    end

    // R12 continuous read over the whole array and across 511 -> 0
    rd_check(0, WORDS + 2, "R12");

    // R7 page wrap: start at offset 14 of page 2
    wren();
    wr_frame(2 * PAGE + 14, 4, 2);
    model_write(2 * PAGE + 14, 4, 2);
    idle();
    rd_check(2 * PAGE, PAGE, "R7");

    // R6 write without enable
    wr_frame(100, 3, 3);
    idle();
    rd_check(100, 3, "R6");
    rdsr(s); chk("R6", s, 8'h00, "status after unenabled write");

    // R7 partial final byte aborts
    wren();
    sel(); xbyte(ins(3'b010, 200), r); xbyte(8'(200), r); xbyte(8'h11, r); xbits(8'hA0, 4, r); desel();
    rdsr(s); chk("R7", s, 8'h00, "status after partial byte");
    rd_check(200, 2, "R7");

    // R7 no data bytes aborts
    wren();
    sel(); xbyte(ins(3'b010, 210), r); xbyte(8'(210), r); desel();
    rdsr(s); chk("R7", s, 8'h00, "status after empty write");

    // R9 a write during busy is ignored even though WEL is still set
    wren();
    wr_frame(300, 1, 4);
    model_write(300, 1, 4);
    wr_frame(310, 1, 5);
    idle();
    rd_check(300, 11, "R9");

    // R9 a read during busy returns zeros
    wren();
    wr_frame(320, 1, 6);
    model_write(320, 1, 6);
    sel(); xbyte(ins(3'b011, 320), r); xbyte(8'(320), r); xbyte(8'h00, r); desel();
    chk("R9", r, 8'h00, "read during busy");
    idle();
    rd_check(320, 1, "R9");

    // R3 output low while deselected
    chk("R3", sdo, 0, "sdo with select high");

    // R11 guard pin low blocks status write and clears WEL
    wpn = 1'b0;
    wren();
    wrsr(8'h0C);
    rdsr(s); chk("R11", s, 8'h00, "status after guarded WRSR");
    wpn = 1'b1;

    // R11 only data bits 3..2 are taken
    wren();
    wrsr(8'hF7);
    mbp = 2'd1;
    rdsr(s); chk("R11", s, 8'h07, "status during WRSR cycle");
    idle();
    rdsr(s); chk("R11", s, 8'h04, "status after WRSR");

    // R10 BP=01 boundary at 384
    wren(); wr_frame(383, 1, 7); model_write(383, 1, 7); idle();
    wren(); wr_frame(384, 1, 7); model_write(384, 1, 7); idle();
    rd_check(383, 2, "R10");

    // R10 BP=10 boundary at 256
    wren(); wrsr(8'h08); mbp = 2'd2; idle();
    wren(); wr_frame(255, 1, 8); model_write(255, 1, 8); idle();
    wren(); wr_frame(256, 1, 8); model_write(256, 1, 8); idle();
    rd_check(255, 2, "R10");

    // R10 BP=11 guards address 0
    wren(); wrsr(8'h0C); mbp = 2'd3; idle();
    wren(); wr_frame(0, 1, 9); model_write(0, 1, 9); idle();
    rd_check(0, 1, "R10");

    // R4 status repeats while clocked
    sel(); xbyte(8'h05, r); xbyte(8'h00, s); xbyte(8'h00, r); desel();
    chk("R4", s, 8'h0C, "first status byte");
    chk("R4", r, 8'h0C, "repeated status byte");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule